// File: doc/BRIEF.md
# Programmable-Timing Static Memory Controller

The block converts single read and write requests from the chip's internal side into the strobe sequences of an asynchronous parallel bus. SRAM-like devices sit on that bus behind several chip-select regions. Each region has its own timing word, which sets a setup length, a strobe length, a hold length, extra strobe wait cycles, a turnaround (data float) gap after reads, the data width (8 or 16 bits) and how byte lanes are signalled. A request is taken through a valid/ready handshake. Its top address bits pick the region and the remaining bits go out on the external address bus unchanged. When the access ends, a one-cycle done pulse is raised, and for a read it carries the captured data.

An access runs through three phases: setup, strobe and hold. The setup and hold phases may be zero cycles long. The strobe phase is at least one cycle and can be stretched by the programmed wait cycles and by an external wait input. The data bus is split into an output value, an output enable and an input value, which the pad ring joins into one tristate bus. A 16-bit region can mark partial writes in one of two ways: a per-lane write strobe for each byte, or a single write strobe plus per-lane select lines.

Top module: `static_mem_ctl`

## Requirements
- R1: While reset is held, and afterwards until the first request, all chip selects, the write strobe, the per-lane strobes, the per-lane selects and the read strobe are high, the data bus is not driven and `req_ready` is 1. After reset every timing word is zero, which gives an 8-bit region in per-lane-strobe style with no setup or hold and a one-cycle strobe.
- R2: The timing word is {bytesel[28], wide[27], float[26:23], waits[22:19], hold[18:13], pulse[12:6], setup[5:0]}. An accepted access keeps its chip select low for exactly setup + P + hold cycles, where P = max(pulse,1) + waits. It starts on the cycle after the accepting clock edge.
- R3: In a write, the data bus is driven for every cycle the chip select is low. A strobe is low for exactly P cycles, and the read strobe stays high throughout.
- R4: In a read, the data bus is never driven. The read strobe is low for exactly P cycles, and `rsp_done` pulses for one cycle after the access, with `rsp_rdata` holding the bus value captured on the last strobe cycle.
- R5: Each unit of the waits field lengthens the strobe phase, and so the access, by one cycle.
- R6: While `mem_wait` is 1 on the last strobe cycle, the strobe phase continues. It ends on the first cycle in which `mem_wait` is seen as 0.
- R7: After a read, `req_ready` stays low for exactly `float` cycles starting with the `rsp_done` cycle. A write adds no such gap.
- R8: In a 16-bit region with bytesel=1, `mem_we_n` strobes whenever any enable is set. `mem_bs_n[i]` is low for the whole access when lane i is enabled on a write, and on every lane for a read. Only the selected lanes of the memory change.
- R9: In a 16-bit region with bytesel=0, `mem_bw_n[i]` strobes only for enabled lanes, and `mem_we_n` and `mem_bs_n` stay high.
- R10: In an 8-bit region, only lane 0 moves data. `mem_we_n` strobes only when enable bit 0 is set, the lane selects stay high, and read data returns with the upper byte zero.
- R11: `req_addr[25:24]` picks which single chip select goes low, and `mem_addr` equals `req_addr[23:0]` for the whole access.
- R12: A timing word written while an access is in progress does not change that access. It applies from the next accepted request.
- R13: At most one chip select is low at a time, and the read strobe is never low together with any write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one region timing word |
| cfg_bank | input | 2 | Region whose timing word is written |
| cfg_wdata | input | 29 | New timing word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 26 | Region select (top 2 bits) and device address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| mem_addr | output | 24 | External address |
| mem_dq_o | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_i | input | 16 | Data bus input value |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_we_n | output | 1 | Active-low common write strobe |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_bw_n | output | 2 | Active-low per-lane write strobes |
| mem_bs_n | output | 2 | Active-low per-lane selects |
| mem_wait | input | 1 | External wait, 1 stretches the strobe |

## Verification
A wrong phase counter or a wrong snapshot of the timing word shows up at the ports within the same access. The chip-select window or a strobe window would come out one or more cycles longer or shorter than the value computed in the bench, and the bench measures those windows cycle by cycle. A wrong lane decode or a wrong capture point shows up as a corrupted memory image or wrong read data when the location is read back, no later than the next access to it. A float counter that is stuck or miscounts shows up in the cycles straight after the read's done pulse, as a ready signal that rises too early or too late.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int SETUP_W = 6;
  localparam int PULSE_W = 7;
  localparam int HOLD_W  = 6;
  localparam int WAIT_W  = 4;
  localparam int FLT_W   = 4;
  localparam int CNT_W   = 8;

  typedef struct packed {
    logic               bytesel;
    logic               wide;
    logic [FLT_W-1:0]   flt;
    logic [WAIT_W-1:0]  waits;
    logic [HOLD_W-1:0]  hold;
    logic [PULSE_W-1:0] pulse;
    logic [SETUP_W-1:0] setup;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;
endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [BANK_W-1:0] rd_bank,
  output bank_cfg_t         rd_cfg
);
  logic [CFG_W-1:0] regs_w [NBANKS];

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    logic [CFG_W-1:0] word_q;
    logic             word_en;
    assign word_en = cfg_we && (cfg_bank == BANK_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= cfg_wdata;
    end
    assign regs_w[g] = word_q;
  end

  assign rd_cfg = bank_cfg_t'(regs_w[rd_bank]);
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      start_wr,
  input  bank_cfg_t start_cfg,
  input  logic      mem_wait,
  output phase_t    phase,
  output logic      act_wr,
  output logic      act_wide,
  output logic      act_bsel,
  output logic      ready,
  output logic      capture,
  output logic      done
);
  phase_t             ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  bank_cfg_t          cfg_q, cfg_d;
  logic               wr_q, wr_d;
  logic [FLT_W-1:0]   flt_q, flt_d;
  logic               done_q, fin;

  function automatic logic [CNT_W-1:0] strobe_len(bank_cfg_t c);
    logic [CNT_W-1:0] base;
    base = (c.pulse == '0) ? CNT_W'(1) : CNT_W'(c.pulse);
    return base + CNT_W'(c.waits);
  endfunction

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    cfg_d = cfg_q;
    wr_d  = wr_q;
    flt_d = flt_q;
    fin   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (flt_q != '0) flt_d = flt_q - FLT_W'(1);
        if (start) begin
          cfg_d = start_cfg;
          wr_d  = start_wr;
          if (start_cfg.setup != '0) begin
            ph_d  = PH_SETUP;
            cnt_d = CNT_W'(start_cfg.setup) - CNT_W'(1);
          end else begin
            ph_d  = PH_PULSE;
            cnt_d = strobe_len(start_cfg) - CNT_W'(1);
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_PULSE;
          cnt_d = strobe_len(cfg_q) - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_PULSE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (!mem_wait) begin
          if (cfg_q.hold != '0) begin
            ph_d  = PH_HOLD;
            cnt_d = CNT_W'(cfg_q.hold) - CNT_W'(1);
          end else begin
            ph_d = PH_IDLE;
            fin  = 1'b1;
          end
        end
      end
      default: begin
        if (cnt_q == '0) begin
          ph_d = PH_IDLE;
          fin  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    endcase
    if (fin && !wr_q) flt_d = cfg_q.flt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      cfg_q  <= '0;
      wr_q   <= 1'b0;
      flt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      cfg_q  <= cfg_d;
      wr_q   <= wr_d;
      flt_q  <= flt_d;
      done_q <= fin;
    end
  end

  assign phase    = ph_q;
  assign act_wr   = wr_q;
  assign act_wide = cfg_q.wide;
  assign act_bsel = cfg_q.bytesel;
  assign ready    = (ph_q == PH_IDLE) && (flt_q == '0);
  assign capture  = (ph_q == PH_PULSE) && (cnt_q == '0) && !mem_wait && !wr_q;
  assign done     = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
  AST_FLOAT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr_q && (cfg_q.flt != '0)) |-> !ready); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q != PH_IDLE) && ($past(ph_q) != PH_IDLE)) |-> $stable(cfg_q)); // R12
endmodule

// File: rtl/smc_pins.sv
module smc_pins
  import smc_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              wr,
  input  logic              wide,
  input  logic              bsel,
  input  logic [BANK_W-1:0] bank,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [NBANKS-1:0] cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [LANES-1:0]  bw_n,
  output logic [LANES-1:0]  bs_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  logic act, strobe;
  assign act    = (phase != PH_IDLE);
  assign strobe = (phase == PH_PULSE);

  for (genvar g = 0; g < NBANKS; g++) begin : g_cs
    assign cs_n[g] = ~(act && (bank == BANK_W'(g)));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bw_n[l] = ~(strobe && wr && wide && !bsel && be[l]);
    assign bs_n[l] = ~(act && wide && bsel && (!wr || be[l]));
  end

  assign we_n  = ~(strobe && wr && (wide ? (bsel && (|be)) : be[0]));
  assign oe_n  = ~(strobe && !wr);
  assign dq_oe = act && wr;
  assign dq_o  = wide ? wdata : {{(DATA_W-8){1'b0}}, wdata[7:0]};

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && (&bw_n))); // R13
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe); // R4
endmodule

// File: rtl/static_mem_ctl.sv
module static_mem_ctl
  import smc_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int BANK_W = $clog2(NBANKS),
  localparam int LANES  = DATA_W / 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [BANK_W-1:0]        cfg_bank,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [BANK_W+ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [LANES-1:0]         req_be,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_dq_o,
  output logic                     mem_dq_oe,
  input  logic [DATA_W-1:0]        mem_dq_i,
  output logic [NBANKS-1:0]        mem_cs_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES-1:0]         mem_bw_n,
  output logic [LANES-1:0]         mem_bs_n,
  input  logic                     mem_wait
);
  logic              start, capture, act_wr, act_wide, act_bsel;
  bank_cfg_t         sel_cfg;
  phase_t            phase;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic [LANES-1:0]  be_q;

  assign start = req_valid && req_ready;

  smc_cfg_regs #(.NBANKS(NBANKS), .BANK_W(BANK_W)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_bank, .cfg_wdata,
    .rd_bank (req_addr[BANK_W+ADDR_W-1:ADDR_W]),
    .rd_cfg  (sel_cfg)
  );

  smc_seq u_seq (
    .clk, .rst_n, .start,
    .start_wr  (req_write),
    .start_cfg (sel_cfg),
    .mem_wait,
    .phase, .act_wr, .act_wide, .act_bsel,
    .ready     (req_ready),
    .capture,
    .done      (rsp_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      bank_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start) begin
      addr_q  <= req_addr[ADDR_W-1:0];
      bank_q  <= req_addr[BANK_W+ADDR_W-1:ADDR_W];
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  assign rdata_d = act_wide ? mem_dq_i : {{(DATA_W-8){1'b0}}, mem_dq_i[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= rdata_d;
  end

  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;

  smc_pins #(.NBANKS(NBANKS), .BANK_W(BANK_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
    .clk, .rst_n, .phase,
    .wr    (act_wr),
    .wide  (act_wide),
    .bsel  (act_bsel),
    .bank  (bank_q),
    .be    (be_q),
    .wdata (wdata_q),
    .cs_n  (mem_cs_n),
    .we_n  (mem_we_n),
    .oe_n  (mem_oe_n),
    .bw_n  (mem_bw_n),
    .bs_n  (mem_bs_n),
    .dq_o  (mem_dq_o),
    .dq_oe (mem_dq_oe)
  );

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&mem_cs_n) && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
endmodule

// File: tb/static_mem_ctl_bench.sv
module static_mem_ctl_bench;
  import smc_pkg::*;
  localparam int NB = 4, AW = 24, DW = 16, LN = 2, BW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, cfg_we, req_valid, req_ready, req_write, rsp_done;
  logic [BW-1:0] cfg_bank;
  logic [CFG_W-1:0] cfg_wdata;
  logic [BW+AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_o, mem_dq_i;
  logic [LN-1:0] req_be, mem_bw_n, mem_bs_n;
  logic [AW-1:0] mem_addr;
  logic          mem_dq_oe, mem_we_n, mem_oe_n, mem_wait;
  logic [NB-1:0] mem_cs_n;

  static_mem_ctl #(.NBANKS(NB), .ADDR_W(AW), .DATA_W(DW)) u_static_mem_ctl (
    .clk, .rst_n, .cfg_we, .cfg_bank, .cfg_wdata, .req_valid, .req_ready,
    .req_write, .req_addr, .req_wdata, .req_be, .rsp_done, .rsp_rdata,
    .mem_addr, .mem_dq_o, .mem_dq_oe, .mem_dq_i, .mem_cs_n, .mem_we_n,
    .mem_oe_n, .mem_bw_n, .mem_bs_n, .mem_wait
  );

  // device model
  logic [DW-1:0] mem [NB][256];
  logic          m_wide [NB];
  logic          m_bsel [NB];

  always_comb begin
    mem_dq_i = '0;
    for (int b = 0; b < NB; b++)
      if (!mem_cs_n[b] && !mem_oe_n) mem_dq_i = mem[b][mem_addr[7:0]];
  end

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!mem_cs_n[b]) begin
        if (!m_wide[b]) begin
          if (!mem_we_n) mem[b][mem_addr[7:0]][7:0] <= mem_dq_o[7:0];
        end else if (m_bsel[b]) begin
          for (int l = 0; l < LN; l++)
            if (!mem_we_n && !mem_bs_n[l]) mem[b][mem_addr[7:0]][l*8 +: 8] <= mem_dq_o[l*8 +: 8];
        end else begin
          for (int l = 0; l < LN; l++)
            if (!mem_bw_n[l]) mem[b][mem_addr[7:0]][l*8 +: 8] <= mem_dq_o[l*8 +: 8];
        end
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_set(input int b, input int s, input int p, input int h,
                         input int w, input int f, input bit wide, input bit bsel);
    bank_cfg_t c;
    c.setup = SETUP_W'(s); c.pulse = PULSE_W'(p); c.hold = HOLD_W'(h);
    c.waits = WAIT_W'(w);  c.flt = FLT_W'(f);     c.wide = wide; c.bytesel = bsel;
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = BW'(b); cfg_wdata = c;
    @(negedge clk);
    cfg_we = 1'b0;
    m_wide[b] = wide; m_bsel[b] = bsel;
  endtask

  int cur_b, cur_a, cur_k;
  int r_cs, r_other, r_addr_bad, r_oe, r_we, r_bw0, r_bw1, r_dqoe, r_pulse, r_bslow;
  logic [LN-1:0] r_bs;
  logic [DW-1:0] r_rd;

  task automatic sample();
    if (!mem_cs_n[cur_b]) r_cs++;
    if (!mem_cs_n[cur_b] && mem_addr != AW'(cur_a)) r_addr_bad++;
    for (int b = 0; b < NB; b++) if (b != cur_b && !mem_cs_n[b]) r_other++;
    if (!mem_oe_n) r_oe++;
    if (!mem_we_n) r_we++;
    if (!mem_bw_n[0]) r_bw0++;
    if (!mem_bw_n[1]) r_bw1++;
    if (mem_dq_oe) r_dqoe++;
    if (mem_bs_n != 2'b11) r_bslow++;
    if (!mem_oe_n || !mem_we_n || mem_bw_n != 2'b11) begin
      r_pulse++;
      r_bs = mem_bs_n;
      if (cur_k > 0 && r_pulse == cur_k) mem_wait = 1'b0;
    end
  endtask

  task automatic run_acc(input int b, input bit wr, input int a, input logic [DW-1:0] d,
                         input logic [LN-1:0] be, input int k);
    cur_b = b; cur_a = a; cur_k = k;
    r_cs = 0; r_other = 0; r_addr_bad = 0; r_oe = 0; r_we = 0; r_bw0 = 0; r_bw1 = 0;
    r_dqoe = 0; r_pulse = 0; r_bslow = 0; r_bs = 2'b11;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {BW'(b), AW'(a)};
    req_wdata = d; req_be = be;
    if (k > 0) mem_wait = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    sample();
    while (!rsp_done) begin
      @(negedge clk);
      sample();
    end
    r_rd = rsp_rdata;
  endtask

  task automatic float_gap(output int n);
    n = 0;
    while (!req_ready) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int gap, pp, tt, idx;
    logic [DW-1:0] d;
    for (int b = 0; b < NB; b++) begin
      m_wide[b] = 1'b0; m_bsel[b] = 1'b0;
      for (int i = 0; i < 256; i++) mem[b][i] = '0;
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_bank = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    mem_wait = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", 32'(mem_cs_n), 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle strobes", {mem_we_n, mem_oe_n, mem_bw_n, mem_bs_n, mem_dq_oe, req_ready},
          {1'b1, 1'b1, 2'b11, 2'b11, 1'b0, 1'b1});
    check("R1 cs_n idle", 32'(mem_cs_n), 32'hF);

    // R1 reset timing word: 8-bit, one-cycle strobe, no setup/hold
    run_acc(0, 1'b1, 3, 16'h4455, 2'b01, 0);
    check("R1 default access length", r_cs, 1);
    check("R10 narrow write strobe", r_we, 1);

    // R2 R3 R4 R5 R11 sweep on a 16-bit byte-select region
    idx = 0;
    for (int s = 0; s <= 2; s++)
      for (int p = 0; p <= 3; p++)
        for (int h = 0; h <= 2; h++)
          for (int w = 0; w <= 1; w++) begin
            cfg_set(1, s, p, h, w, 0, 1'b1, 1'b1);
            pp = ((p == 0) ? 1 : p) + w;
            tt = s + pp + h;
            d  = DW'(idx * 16'h0101) ^ 16'h5A3C;
            run_acc(1, 1'b1, 100 + idx, d, 2'b11, 0);
            check("R2 write cs window", r_cs, tt);
            check("R5 write strobe length", r_pulse, pp);
            check("R3 write drive window", r_dqoe, tt);
            check("R3 write read strobe quiet", r_oe, 0);
            check("R11 decode and address", r_other + r_addr_bad, 0);
            run_acc(1, 1'b0, 100 + idx, 16'h0, 2'b11, 0);
            check("R2 read cs window", r_cs, tt);
            check("R4 read strobe length", r_oe, pp);
            check("R4 read never drives", r_dqoe, 0);
            check("R4 read data", r_rd, d);
            idx++;
          end

    // R8 byte-select lanes
    cfg_set(1, 1, 2, 1, 0, 0, 1'b1, 1'b1);
    run_acc(1, 1'b1, 40, 16'h1234, 2'b11, 0);
    run_acc(1, 1'b1, 40, 16'hABCD, 2'b10, 0);
    check("R8 lane select pattern", 32'(r_bs), 32'h1);
    check("R8 common strobe cycles", r_we, 2);
    run_acc(1, 1'b0, 40, 16'h0, 2'b11, 0);
    check("R8 partial write merge", r_rd, 16'hAB34);

    // R6 external wait holds the strobe
    run_acc(1, 1'b0, 40, 16'h0, 2'b11, 6);
    check("R6 stretched strobe", r_oe, 6);
    check("R6 stretched access", r_cs, 8);
    check("R6 read data", r_rd, 16'hAB34);

    // R9 byte-write lanes
    cfg_set(2, 0, 3, 0, 0, 0, 1'b1, 1'b0);
    run_acc(2, 1'b1, 7, 16'h5678, 2'b11, 0);
    check("R9 lane0 strobe", r_bw0, 3);
    check("R9 lane1 strobe", r_bw1, 3);
    run_acc(2, 1'b1, 7, 16'h9A9A, 2'b01, 0);
    check("R9 only lane0", {16'(r_bw0), 16'(r_bw1)}, {16'd3, 16'd0});
    check("R9 common strobe and selects quiet", r_we + r_bslow, 0);
    run_acc(2, 1'b0, 7, 16'h0, 2'b11, 0);
    check("R9 partial write merge", r_rd, 16'h569A);

    // R7 float gap after read only
    cfg_set(2, 0, 1, 0, 0, 3, 1'b1, 1'b0);
    run_acc(2, 1'b0, 7, 16'h0, 2'b11, 0);
    float_gap(gap);
    check("R7 gap after read", gap, 3);
    run_acc(2, 1'b1, 8, 16'h1111, 2'b11, 0);
    float_gap(gap);
    check("R7 no gap after write", gap, 0);

    // R10 8-bit region
    cfg_set(0, 1, 1, 1, 0, 0, 1'b0, 1'b0);
    run_acc(0, 1'b1, 9, 16'h77C3, 2'b01, 0);
    check("R10 narrow selects quiet", r_bslow, 0);
    check("R10 narrow drive value low byte", r_we, 1);
    run_acc(0, 1'b1, 9, 16'h77EE, 2'b10, 0);
    check("R10 lane0 disabled no strobe", r_we, 0);
    run_acc(0, 1'b0, 9, 16'h0, 2'b11, 0);
    check("R10 narrow read zero upper", r_rd, 16'h00C3);

    // R12 new timing word only for next access
    cfg_set(3, 5, 2, 0, 0, 0, 1'b1, 1'b1);
    fork
      run_acc(3, 1'b0, 1, 16'h0, 2'b11, 0);
      begin
        repeat (3) @(negedge clk);
        cfg_set(3, 1, 2, 0, 0, 0, 1'b1, 1'b1);
      end
    join
    check("R12 running access unchanged", r_cs, 7);
    run_acc(3, 1'b0, 1, 16'h0, 2'b11, 0);
    check("R12 next access uses new word", r_cs, 3);
    check("R11 other selects quiet", r_other, 0);

    finish_run();
  end
endmodule